// File: doc/BRIEF.md
# Bit-Matrix Least-Recently-Used Frame Tracker

This block keeps the use order of a set of page frames and names the frame that has gone unused the longest. It holds one row and one column of bits for each frame, so N frames need N×N bits. Whenever a frame is referenced, its row is filled with ones and then its column is cleared in every row. At any moment, the frame whose row reads as the smallest binary number is the replacement candidate.

A replacement engine drives a reference strobe with a frame index on every access. It reads the candidate from the victim output, which follows the matrix registers combinationally. A debug select lets one row of the matrix be read out at a time. The frame count is a parameter, from 2 to 16, with a default of 4.

Top module: `lru_matrix_tracker`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears every bit of the matrix, so every row reads 0 and the victim is frame 0.
- R2: A reference to frame k (`refValid` high at a clock edge) leaves row k with a 1 in every column except column k.
- R3: The same reference clears column k in every row, including bit (k,k).
- R4: The victim is the frame whose row, read as a binary number with column 0 as the most significant bit, has the smallest value.
- R5: When several rows share the smallest value, the victim is the lowest frame index among them.
- R6: The matrix update takes effect on the clock edge that samples the strobe. The victim output reflects the new matrix right after that edge and does not change before it.
- R7: On 4 frames, the reference sequence 0,1,2,3,2,1,0,3,2,3 leaves frame 1 as the victim, and the victim follows the true use order after every step.
- R8: While `refValid` is low, the matrix and the victim stay unchanged.
- R9: `victimValid` is high in every cycle after the first reset.
- R10: `dbgRow` returns the row selected by `dbgSel`, with column j at bit position N-1-j.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| refValid | input | 1 | Reference strobe |
| refFrame | input | $clog2(N) | Frame index being referenced |
| dbgSel | input | $clog2(N) | Matrix row selected for debug readout |
| dbgRow | output | N | Selected row; column 0 is the MSB |
| victimFrame | output | $clog2(N) | Least recently used frame |
| victimValid | output | 1 | High once reset has been applied |

## Verification
The assertions assume that `refFrame` holds a valid frame index whenever `refValid` is high. Out-of-range indices are gated off and never produce an update. They also assume that reset is applied before the first reference, because the matrix starts out unknown. The bench asserts reset from time zero and only references indices below N. It changes every input at the falling clock edge, so each strobe is sampled cleanly at exactly one rising edge.

// File: rtl/lru_pkg.sv
`timescale 1ns/1ps
package lru_pkg;
  typedef struct packed {
    logic clearAll;
    logic touch;
  } lruStrobes_t;
endpackage

// File: rtl/lru_ctrl.sv
`timescale 1ns/1ps
module lru_ctrl
  import lru_pkg::*;
#(
  parameter int N = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             refValid,
  input  logic [IDX_W-1:0] refFrame,
  output lruStrobes_t      ctl,
  output logic             victimValid
);
  logic frameInRange;
  logic validQ;

  assign frameInRange = (int'(refFrame) < N);

  always_comb begin
    ctl.clearAll = rst;
    ctl.touch    = refValid && !rst && frameInRange;
  end

  always_ff @(posedge clk) begin
    if (rst) validQ <= 1'b1;
  end

  assign victimValid = validQ;

  AST_VALID_HIGH: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> victimValid); // R9
endmodule

// File: rtl/lru_victim_sel.sv
`timescale 1ns/1ps
module lru_victim_sel #(
  parameter int N = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0][N-1:0] rows,
  output logic [IDX_W-1:0]    victim
);
  logic [N-1:0] bestVal;

  always_comb begin
    victim  = '0;
    bestVal = rows[0];
    for (int i = 1; i < N; i++) begin
      if (rows[i] < bestVal) begin
        bestVal = rows[i];
        victim  = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/lru_datapath.sv
`timescale 1ns/1ps
module lru_datapath
  import lru_pkg::*;
#(
  parameter int N = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  lruStrobes_t      ctl,
  input  logic [IDX_W-1:0] refFrame,
  input  logic [IDX_W-1:0] dbgSel,
  output logic [N-1:0]     dbgRow,
  output logic [IDX_W-1:0] victimFrame
);
  logic [N-1:0][N-1:0] rowsQ;
  logic [N-1:0]        colMask;

  always_comb begin
    colMask = '0;
    for (int j = 0; j < N; j++) begin
      colMask[N-1-j] = (refFrame == IDX_W'(j));
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (ctl.clearAll) begin
        rowsQ[i] <= '0;
      end else if (ctl.touch) begin
        if (refFrame == IDX_W'(i)) rowsQ[i] <= ~colMask;
        else                       rowsQ[i] <= rowsQ[i] & ~colMask;
      end
    end
  end

  assign dbgRow = (int'(dbgSel) < N) ? rowsQ[dbgSel] : '0;

  lru_victim_sel #(.N(N)) u_sel (
    .rows   (rowsQ),
    .victim (victimFrame)
  );

  AST_RESET_EMPTY: assert property (@(posedge clk) ctl.clearAll |=> (rowsQ == '0)); // R1
  AST_TOUCH_NOT_VICTIM: assert property (@(posedge clk) disable iff (ctl.clearAll)
    ctl.touch |=> (victimFrame != $past(refFrame))); // R4
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (ctl.clearAll)
    !ctl.touch |=> $stable(rowsQ)); // R8
  AST_TOUCH_ROW_FULL: assert property (@(posedge clk) disable iff (ctl.clearAll)
    ctl.touch |=> ($countones(rowsQ[$past(refFrame)]) == N-1)); // R2
endmodule

// File: rtl/lru_matrix_tracker.sv
`timescale 1ns/1ps
module lru_matrix_tracker
  import lru_pkg::*;
#(
  parameter int N = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             refValid,
  input  logic [IDX_W-1:0] refFrame,
  input  logic [IDX_W-1:0] dbgSel,
  output logic [N-1:0]     dbgRow,
  output logic [IDX_W-1:0] victimFrame,
  output logic             victimValid
);
  lruStrobes_t ctl;

  lru_ctrl #(.N(N)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .refValid    (refValid),
    .refFrame    (refFrame),
    .ctl         (ctl),
    .victimValid (victimValid)
  );

  lru_datapath #(.N(N)) u_dp (
    .clk         (clk),
    .ctl         (ctl),
    .refFrame    (refFrame),
    .dbgSel      (dbgSel),
    .dbgRow      (dbgRow),
    .victimFrame (victimFrame)
  );
endmodule

// File: tb/sim_lru_matrix_tracker.sv
`timescale 1ns/1ps
module sim_lru_matrix_tracker;
  localparam int N = 4;
  localparam int IDX_W = $clog2(N);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             refValid = 1'b0;
  logic [IDX_W-1:0] refFrame = '0;
  logic [IDX_W-1:0] dbgSel = '0;
  logic [N-1:0]     dbgRow;
  logic [IDX_W-1:0] victimFrame;
  logic             victimValid;

  int checkCount = 0;
  int failCount  = 0;
  int lastUse [N];
  int tick = 0;

  always #2.5 clk = ~clk;

  lru_matrix_tracker #(.N(N)) u0 (
    .clk(clk), .rst(rst), .refValid(refValid), .refFrame(refFrame),
    .dbgSel(dbgSel), .dbgRow(dbgRow), .victimFrame(victimFrame),
    .victimValid(victimValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expVictim();
    int best = 0;
    for (int i = 1; i < N; i++) if (lastUse[i] < lastUse[best]) best = i;
    return best;
  endfunction

  function automatic logic [N-1:0] expRow(input int k);
    logic [N-1:0] r = '0;
    for (int j = 0; j < N; j++)
      r[N-1-j] = (k != j) && (lastUse[k] >= 0) && (lastUse[k] > lastUse[j]);
    return r;
  endfunction

  task automatic modelClear();
    for (int i = 0; i < N; i++) lastUse[i] = -1;
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1; refValid = 1'b0;
    @(negedge clk); rst = 1'b0;
    modelClear();
  endtask

  task automatic checkRows(input string req);
    for (int k = 0; k < N; k++) begin
      dbgSel = IDX_W'(k);
      #0.5;
      check(dbgRow == expRow(k), req, int'(dbgRow), int'(expRow(k)));
    end
  endtask

  task automatic doRef(input int k, input string req);
    @(negedge clk);
    refValid = 1'b1; refFrame = IDX_W'(k);
    #1;
    check(int'(victimFrame) == expVictim(), "R6 before edge", int'(victimFrame), expVictim());
    @(negedge clk);
    refValid = 1'b0;
    lastUse[k] = tick; tick++;
    check(int'(victimFrame) == expVictim(), req, int'(victimFrame), expVictim());
  endtask

  task automatic t_reset();
    doReset();
    check(victimFrame == 0, "R1 victim after reset", int'(victimFrame), 0);
    check(victimValid == 1'b1, "R9 valid", int'(victimValid), 1);
    checkRows("R1 rows zero");
  endtask

  task automatic t_single();
    doReset();
    doRef(2, "R5 tie lowest index");
    check(victimFrame == 0, "R5 victim", int'(victimFrame), 0);
    checkRows("R2 R3 single ref rows");
    doRef(2, "R2 repeat ref");
    checkRows("R2 repeat rows");
  endtask

  task automatic t_sequence();
    int seq [10] = '{0, 1, 2, 3, 2, 1, 0, 3, 2, 3};
    doReset();
    foreach (seq[i]) doRef(seq[i], "R7 step victim");
    check(victimFrame == 1, "R7 final victim", int'(victimFrame), 1);
    checkRows("R10 rows after sequence");
  endtask

  task automatic t_msb();
    doReset();
    doRef(1, "R4 order");
    doRef(2, "R4 order");
    doRef(0, "R4 order");
    check(victimFrame == 3, "R4 column 0 is MSB", int'(victimFrame), 3);
    dbgSel = 2'd0; #0.5;
    check(dbgRow == 4'b0111, "R10 row 0", int'(dbgRow), 7);
    dbgSel = 2'd1; #0.5;
    check(dbgRow == 4'b0001, "R3 row 1", int'(dbgRow), 1);
  endtask

  task automatic t_idle();
    doRef(3, "R4 victim");
    refFrame = 2'd1;
    repeat (5) @(negedge clk);
    check(int'(victimFrame) == expVictim(), "R8 idle victim", int'(victimFrame), expVictim());
    checkRows("R8 idle rows");
  endtask

  task automatic t_midReset();
    doRef(0, "R4 victim");
    doReset();
    check(victimFrame == 0, "R1 mid reset victim", int'(victimFrame), 0);
    checkRows("R1 mid reset rows");
    check(victimValid == 1'b1, "R9 valid after reset", int'(victimValid), 1);
  endtask

  initial begin
    modelClear();
    fork
      begin
        t_reset();
        t_single();
        t_sequence();
        t_msb();
        t_idle();
        t_midReset();
      end
      begin
        #1000000;
        checkCount++; failCount++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule